// File: doc/BRIEF.md
# Symbol-Compare Round-Robin Arbiter with Merged Data Multiplexer

This block shares one output among N requesters under a round-robin policy and, in the same cycle, routes the winner's data word to the output. A registered priority vector in thermometer code splits the positions into a favoured segment (bits set) and a disfavoured segment (bits clear). Each position's request bit and priority bit are read together as a two-bit number, value twice the request plus the priority. Picking the lowest-indexed position that holds the largest such number gives the same winner as a cyclic scan that starts at the favoured position, but the logic has no loop.

A balanced binary tree of two-input compare nodes finds that winner. Each node passes on the larger number and a direction flag, which is 1 only when the higher-index (left) side is strictly larger. Every position starts out as a possible winner. At each level, the flags clear the grant bits of the subtree that lost. The same flags drive a 2-to-1 data selector beside each node, so no separate output multiplexer is needed. After a grant, the priority vector moves so that the position just above the winner is favoured next. The block has no state machine: its only state is the priority register, which is either held or loaded on each clock edge.

Top module: `rrm_arbmux`

## Requirements
- R1: While reset is active, and after it is released, the priority vector is all ones. With every request active in the first cycle after reset, position 0 is granted.
- R2: The grant vector has at most one bit set, that bit is always at a requesting position, and exactly one bit is set whenever any request is active.
- R3: `any_grant` is 1 exactly when at least one request bit is 1.
- R4: The grant goes to the first active request found by scanning upward from the currently favoured position and wrapping from N-1 to 0. The favoured position is the lowest index whose priority bit is 1. Grant, `any_grant` and `data_out` are combinational in the same cycle.
- R5: After a grant at position i < N-1, the next cycle favours position i+1: priority bits above i are set, and bits at i and below are cleared. After a grant at N-1, the priority vector becomes all ones, which favours position 0.
- R6: In a cycle with no active request, the grant vector is zero, `data_out` is zero, and the priority vector keeps its value.
- R7: `data_out` equals the W-bit word of the granted position, where word k occupies bits [k*W +: W] of `data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the priority register loads on the rising edge |
| rst_n | input | 1 | Active-low reset; sets the priority vector to all ones |
| req | input | N | Request bit per position |
| data_in | input | N*W | Data words, word k at bits [k*W +: W] |
| grant | output | N | One-hot grant, zero when there is no request |
| any_grant | output | 1 | High when any request is active |
| data_out | output | W | Data word of the granted position, zero when idle |

## Verification
Grant, `any_grant` and `data_out` respond in the same cycle as the request and data they depend on. The effect of a grant on the priority vector first shows up in the grant of the following cycle, after one rising edge. The bench therefore drives inputs at the falling edge and compares the outputs one time unit later, well before the next rising edge. It advances its own round-robin pointer only after that comparison, so each expected grant reflects exactly the grants of earlier cycles.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
    // Two-bit symbol: {request, priority}
    typedef logic [1:0] sym_t;
    localparam sym_t SYM_IDLE_LO = 2'd0;
    localparam sym_t SYM_ACT_LO  = 2'd2;

    function automatic sym_t make_sym(input logic r, input logic p);
        return {r, p};
    endfunction
endpackage

// File: rtl/rrm_node.sv
module rrm_node
    import rrm_pkg::*;
#(
    parameter int W = 8
) (
    input  sym_t         sym_l,
    input  sym_t         sym_r,
    input  logic [W-1:0] dat_l,
    input  logic [W-1:0] dat_r,
    output sym_t         sym_o,
    output logic [W-1:0] dat_o,
    output logic         pick_l
);
    // Left wins only when strictly larger; a tie points right.
    always_comb begin
        pick_l = (sym_l > sym_r);
        sym_o  = pick_l ? sym_l : sym_r;
        dat_o  = pick_l ? dat_l : dat_r;
    end
endmodule

// File: rtl/rrm_tree.sv
module rrm_tree
    import rrm_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N-1:0]   req,
    input  logic [N-1:0]   prio,
    input  logic [N*W-1:0] data_in,
    output logic [N-1:0]   spec_grant,
    output sym_t           root_sym,
    output logic [W-1:0]   root_dat
);
    localparam int LV = $clog2(N);
    localparam int NP = 1 << LV;

    // Heap layout: node 1 is the root, leaf k sits at NP+k,
    // node n has left child 2n+1 and right child 2n.
    sym_t         sym_h  [1:2*NP-1];
    logic [W-1:0] dat_h  [1:2*NP-1];
    logic         flag_h [1:NP-1];

    for (genvar k = 0; k < NP; k++) begin : g_leaf
        if (k < N) begin : g_real
            assign sym_h[NP+k] = make_sym(req[k], prio[k]);
            assign dat_h[NP+k] = data_in[k*W +: W];
        end else begin : g_pad
            assign sym_h[NP+k] = SYM_IDLE_LO;
            assign dat_h[NP+k] = '0;
        end
    end

    for (genvar n = 1; n < NP; n++) begin : g_node
        rrm_node #(.W(W)) u_node (
            .sym_l  (sym_h[2*n+1]),
            .sym_r  (sym_h[2*n]),
            .dat_l  (dat_h[2*n+1]),
            .dat_r  (dat_h[2*n]),
            .sym_o  (sym_h[n]),
            .dat_o  (dat_h[n]),
            .pick_l (flag_h[n])
        );
    end

    // Speculative grants: each leaf keeps its bit only while every
    // ancestor's flag points toward its side.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            int m;
            logic keep;
            m    = NP + k;
            keep = 1'b1;
            for (int l = 0; l < LV; l++) begin
                if (flag_h[m >> 1] != m[0]) keep = 1'b0;
                m = m >> 1;
            end
            spec_grant[k] = keep;
        end
    end

    assign root_sym = sym_h[1];
    assign root_dat = dat_h[1];
endmodule

// File: rtl/rrm_prio.sv
module rrm_prio #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grant,
    input  logic         any_grant,
    output logic [N-1:0] prio
);
    logic [N-1:0] prio_nxt;

    always_comb begin
        prio_nxt = prio;
        if (any_grant) begin
            if (grant[N-1]) prio_nxt = '1;
            else            prio_nxt = ~(grant | (grant - 1'b1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prio <= '1;
        else        prio <= prio_nxt;
    end

    // R5
    prio_therm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((~prio) & ((~prio) + 1'b1)) == '0) && (prio != '0));
    // R6
    prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_grant |=> $stable(prio));
    // R5
    prio_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_grant && !grant[N-1]) |=> ((prio & $past(grant)) == '0));
    // R5
    prio_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_grant && grant[N-1]) |=> (&prio));
endmodule

// File: rtl/rrm_arbmux.sv
module rrm_arbmux
    import rrm_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic [N*W-1:0] data_in,
    output logic [N-1:0]   grant,
    output logic           any_grant,
    output logic [W-1:0]   data_out
);
    logic [N-1:0] prio;
    logic [N-1:0] spec_grant;
    sym_t         root_sym;
    logic [W-1:0] root_dat;

    rrm_tree #(.N(N), .W(W)) u_tree (
        .req        (req),
        .prio       (prio),
        .data_in    (data_in),
        .spec_grant (spec_grant),
        .root_sym   (root_sym),
        .root_dat   (root_dat)
    );

    always_comb begin
        any_grant = (root_sym >= SYM_ACT_LO);
        grant     = any_grant ? spec_grant : '0;
        data_out  = any_grant ? root_dat : '0;
    end

    rrm_prio #(.N(N)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .any_grant (any_grant),
        .prio      (prio)
    );

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));
    // R3
    any_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_grant == (req != '0));
    // R2
    grant_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> ($countones(grant) == 1));
    // R6
    data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (data_out == '0));
endmodule

// File: tb/sim_rrm_arbmux.sv
module sim_rrm_arbmux;
    localparam int N      = 8;
    localparam int W      = 8;
    localparam int CLK_NS = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [N*W-1:0] data_in = '0;
    logic [N-1:0]   grant;
    logic           any_grant;
    logic [W-1:0]   data_out;

    int n_run  = 0;
    int n_fail = 0;
    int ptr    = 0;
    logic [7:0] salt = 8'h11;

    always #(CLK_NS/2) clk = ~clk;

    rrm_arbmux #(.N(N), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .data_in(data_in),
        .grant(grant), .any_grant(any_grant), .data_out(data_out)
    );

    function automatic logic [W-1:0] word_of(input int k, input logic [7:0] s);
        return W'((k * 37) ^ s);
    endfunction

    // Drive at falling edge, check 1 time unit later, then advance model.
    task automatic step(input logic [N-1:0] r, input string tag);
        logic [N-1:0] eg;
        logic [W-1:0] ed;
        int win;
        @(negedge clk);
        salt = salt * 8'd5 + 8'd3;
        req  = r;
        for (int k = 0; k < N; k++) data_in[k*W +: W] = word_of(k, salt);
        #1;
        eg = '0; ed = '0; win = -1;
        for (int j = 0; j < N; j++) begin
            int pos;
            pos = (ptr + j) % N;
            if (win < 0 && r[pos]) win = pos;
        end
        if (win >= 0) begin
            eg[win] = 1'b1;
            ed = word_of(win, salt);
        end
        n_run++;
        if (grant !== eg) begin
            n_fail++;
            $display("FAIL %s R4 grant: actual %b expected %b", tag, grant, eg);
        end
        n_run++;
        if (any_grant !== (win >= 0)) begin
            n_fail++;
            $display("FAIL %s R3 any_grant: actual %b expected %b", tag, any_grant, win >= 0);
        end
        n_run++;
        if (data_out !== ed) begin
            n_fail++;
            $display("FAIL %s R7 data_out: actual %h expected %h", tag, data_out, ed);
        end
        if (win >= 0) ptr = (win + 1) % N;
    endtask

    task automatic t_reset;
        // R1: all requests right after reset -> position 0
        step('1, "R1 reset");
    endtask

    task automatic t_full_rotation;
        // R4 R5: all active, grant walks 1..N-1 then wraps to 0
        for (int i = 0; i < N + 2; i++) step('1, "R5 rotation");
    endtask

    task automatic t_sparse;
        // R4: winner found in disfavoured segment when favoured is empty
        step(8'b0010_0101, "R4 sparse a");
        step(8'b0010_0101, "R4 sparse b");
        step(8'b0000_0001, "R4 wrap low");
        step(8'b1000_0000, "R5 top grant");
        step(8'b0000_0011, "R5 after top");
    endtask

    task automatic t_idle;
        // R6: no request holds priority and zeroes outputs
        step(8'b0001_0000, "R6 set");
        step('0, "R6 idle a");
        step('0, "R6 idle b");
        step('1, "R6 held ptr");
    endtask

    task automatic t_single;
        // R2: one requester repeatedly granted
        for (int i = 0; i < 4; i++) step(8'b0100_0000, "R2 single");
    endtask

    task automatic t_pseudo;
        logic [N-1:0] lf;
        lf = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[N-2:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step((i % 7 == 3) ? '0 : lf, "R2 pseudo");
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (grant !== '0 || data_out !== '0) begin
            n_fail++;
            $display("FAIL R1 idle in reset: actual %b/%h expected 0/0", grant, data_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_rotation();
        t_sparse();
        t_idle();
        t_single();
        t_pseudo();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule